// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is the slave side of a mode-0 SPI link in front of a byte-wide memory array that is held inside the block. A host frames each command with an active-low chip select. The first byte of a frame is a command byte. It can arm writes, read or change a small status byte, or start a streaming read or write. A streaming access runs at link speed with no page buffer. Each data byte goes to the array as soon as its last bit arrives. The address steps forward on every byte and wraps at the top of the array, for as long as the host keeps clocking with chip select low.

Writes are guarded in two ways. A write-enable latch must be armed in a separate earlier frame. A two-bit protect field in the status byte fences off part of the array. A protect-enable bit in the status byte, together with an active-low write-protect pin, decides whether the status byte itself can be changed. An active-low pause pin freezes a frame in the middle and lets it continue later. While paused, or while the block is not selected, the serial output driver is disabled.

All pins are sampled on the system clock through two-flop synchronizers. The serial clock must be slow enough that each half period spans at least four system clocks. The array holds 2**ADDR_W bytes: ADDR_W=13 gives the 8K x 8 configuration, and the default is smaller to keep elaboration light.

Top module: `spi_bytemem`

## Requirements
- R1: Command byte 06h arms the write-enable latch when chip select rises at the end of that frame. Command 05h returns the status byte {PE, 3'b000, P1, P0, WEL, 1'b0} (bit 7 down to bit 0), where PE is protect-enable and P1:P0 is the protect field. This byte repeats for as long as clocks continue.
- R2: Command 02h (write) is accepted only while the latch is set. Otherwise the rest of that frame changes nothing.
- R3: Commands 03h (read) and 02h (write) are followed by a 16-bit address sent high byte first. Only its low ADDR_W bits are used.
- R4: After each data byte the address advances by one, and it wraps from the top address to zero.
- R5: Data moves MSB first. The first read bit is driven after the falling clock edge that follows the last address bit. The serial input has no effect during read data.
- R6: A write byte is stored to the array after its 8th bit. A byte cut short by chip select rising is discarded.
- R7: The write-enable latch clears when chip select rises at the end of a frame whose 02h or 01h command was accepted.
- R8: Command 01h followed by a byte sets PE from bit 7 and P1:P0 from bits 3:2, but only if the latch is set and either PE=0 or the write-protect pin is high. Otherwise the status byte is unchanged.
- R9: The protect field blocks array writes as follows: 00 blocks none, 01 blocks the upper quarter, 10 blocks the upper half, and 11 blocks every address. This holds even while the latch is set.
- R10: If the pause pin goes low while the serial clock is low, clock edges are ignored until the pin goes high again while the clock is low. The frame then continues without losing any bits.
- R11: The output enable is low while chip select is high or a pause is active. Any other command byte makes the block ignore the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| wrprot_n | input | 1 | Active-low write-protect pin for the status byte |
| pause_n | input | 1 | Active-low pause pin |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output-driver enable for miso |

## Verification
The bench fills the whole array in one streaming write that runs past the top address. It then reads the whole array back in one streaming read while driving changing garbage on the serial input. A design that failed to wrap, or that let the input leak into read data, would return a shifted or corrupted pattern. For every protect-field setting, the bench writes across the quarter, half and top-of-array boundaries. A wrong region decode would then store bytes on the wrong side of the fence. The bench also tries status writes for each combination of PE, pin and latch, a truncated byte, writes without arming, unknown commands, and upper address bits. It pauses in the middle of an address byte, a write byte and a read byte while toggling the clock; a design that counted those edges would slip a bit.

// File: rtl/spi_bytemem.sv
module spi_bytemem #(
  parameter int ADDR_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wrprot_n,
  input  logic pause_n,
  output logic miso,
  output logic miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_WDAT, S_RDAT, S_RDSR, S_WRSR, S_IGN} st_t;

  logic [1:0] sck_m, cs_m, mosi_m, pause_m, wp_m;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_m <= 2'b00; cs_m <= 2'b11; mosi_m <= 2'b00; pause_m <= 2'b11; wp_m <= 2'b11;
    end else begin
      sck_m <= {sck_m[0], sck};   cs_m <= {cs_m[0], cs_n};
      mosi_m <= {mosi_m[0], mosi}; pause_m <= {pause_m[0], pause_n};
      wp_m <= {wp_m[0], wrprot_n};
    end

  wire sck_s = sck_m[1];
  wire cs_s  = cs_m[1];
  wire mosi_s = mosi_m[1];
  wire pause_s = pause_m[1];
  wire wp_s = wp_m[1];

  logic sck_q, cs_q, hold_act;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; hold_act <= 1'b0;
    end else begin
      sck_q <= sck_s; cs_q <= cs_s;
      if (!sck_s) hold_act <= ~pause_s;
    end

  wire live = ~cs_s & ~hold_act;
  wire rise = live & sck_s & ~sck_q;
  wire fall = live & ~sck_s & sck_q;

  st_t st;
  logic [3:0] bitcnt;
  logic [15:0] sh;
  logic [ADDR_W-1:0] addr;
  logic [7:0] ob;
  logic miso_r, wel, wpen, wren_p, wclr, rd;
  logic [1:0] bp;
  logic [7:0] mem [DEPTH];

  wire [15:0] sh_nx = {sh[14:0], mosi_s};
  wire byte_done = rise & (bitcnt[2:0] == 3'd7);
  wire [ADDR_W-1:0] addr_inc = addr + 1'b1;
  wire [7:0] sr = {wpen, 3'b000, bp, wel, 1'b0};
  wire sr_ok = wel & (~wpen | wp_s);
  wire in_wdat = (st == S_WDAT);

  logic prot;
  always_comb
    case (bp)
      2'b00: prot = 1'b0;
      2'b01: prot = addr[ADDR_W-1] & addr[ADDR_W-2];
      2'b10: prot = addr[ADDR_W-1];
      default: prot = 1'b1;
    endcase

  wire mem_we = byte_done & in_wdat & ~prot;

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= sh_nx[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OP; bitcnt <= '0; sh <= '0; addr <= '0; ob <= '0; miso_r <= 1'b0;
      wel <= 1'b0; wpen <= 1'b0; bp <= 2'b00; wren_p <= 1'b0; wclr <= 1'b0; rd <= 1'b0;
    end else if (cs_s) begin
      st <= S_OP; bitcnt <= '0; wren_p <= 1'b0; wclr <= 1'b0;
      if (!cs_q) begin
        if (wclr) wel <= 1'b0;
        else if (wren_p) wel <= 1'b1;
      end
    end else begin
      if (fall && (st == S_RDAT || st == S_RDSR)) begin
        miso_r <= ob[7];
        ob <= {ob[6:0], 1'b0};
      end
      if (rise) begin
        sh <= sh_nx;
        bitcnt <= bitcnt + 1'b1;
        if (byte_done)
          case (st)
            S_OP: begin
              bitcnt <= '0;
              case (sh_nx[7:0])
                8'h06: begin wren_p <= 1'b1; st <= S_IGN; end
                8'h05: begin ob <= sr; st <= S_RDSR; end
                8'h01: if (wel) begin wclr <= 1'b1; st <= S_WRSR; end
                       else st <= S_IGN;
                8'h03: begin rd <= 1'b1; st <= S_ADDR; end
                8'h02: if (wel) begin rd <= 1'b0; wclr <= 1'b1; st <= S_ADDR; end
                       else st <= S_IGN;
                default: st <= S_IGN;
              endcase
            end
            S_ADDR:
              if (bitcnt == 4'd15) begin
                addr <= sh_nx[ADDR_W-1:0];
                if (rd) begin
                  ob <= mem[sh_nx[ADDR_W-1:0]];
                  st <= S_RDAT;
                end else st <= S_WDAT;
              end
            S_WDAT: addr <= addr_inc;
            S_RDAT: begin addr <= addr_inc; ob <= mem[addr_inc]; end
            S_RDSR: ob <= sr;
            S_WRSR: begin
              if (sr_ok) begin wpen <= sh_nx[7]; bp <= sh_nx[3:2]; end
              st <= S_IGN;
            end
            default: ;
          endcase
      end
    end

  assign miso = miso_r;
  assign miso_oe = ~cs_s & ~hold_act;
endmodule

// File: rtl/spi_bytemem_chk.sv
module spi_bytemem_chk #(
  parameter int AW = 10
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic hold_act,
  input logic wel,
  input logic wpen,
  input logic [1:0] bp,
  input logic wp_s,
  input logic mem_we,
  input logic byte_done,
  input logic in_wdat,
  input logic [AW-1:0] addr,
  input logic [3:0] bitcnt
);
  AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> wel); // R2
  AST_FULL_FENCE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> bp != 2'b11); // R9
  AST_SR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bp != $past(bp) || wpen != $past(wpen)) |-> ($past(wel) && (!$past(wpen) || $past(wp_s)))); // R8
  AST_WEL_SET_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(wel) |-> cs_s); // R1
  AST_WEL_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(wel) |-> cs_s); // R7
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_wdat && addr == '1) |=> addr == '0); // R4
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && $past(hold_act) && !cs_s) |-> $stable(bitcnt)); // R10
endmodule

bind spi_bytemem spi_bytemem_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .hold_act(hold_act), .wel(wel), .wpen(wpen),
  .bp(bp), .wp_s(wp_s), .mem_we(mem_we), .byte_done(byte_done), .in_wdat(in_wdat),
  .addr(addr), .bitcnt(bitcnt)
);

// File: tb/spi_bytemem_tb.sv
module spi_bytemem_tb;
  localparam int AW = 8;
  localparam int N = 1 << AW;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wrprot_n = 1'b1, pause_n = 1'b1;
  logic miso, miso_oe;
  int nchk = 0, nfail = 0;
  logic [7:0] exp_m [N];

  always #4 clk = ~clk;

  spi_bytemem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .wrprot_n(wrprot_n), .pause_n(pause_n), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int hold_at);
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_at) begin
        pause_n = 1'b0; wt(HP);
        chk("R10 oe low while paused", {7'b0, miso_oe}, 8'h00);
        repeat (3) begin sck = 1'b1; wt(HP); sck = 1'b0; wt(HP); end
        pause_n = 1'b1; wt(HP);
      end
      mosi = tx[i]; wt(HP);
      rx[i] = miso;
      sck = 1'b1; wt(HP);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xbyte(tx, d, -1);
  endtask

  task automatic cs_lo; cs_n = 1'b0; wt(HP); endtask
  task automatic cs_hi; wt(HP); cs_n = 1'b1; wt(2*HP); endtask

  task automatic wren; cs_lo(); send(8'h06); cs_hi(); endtask

  task automatic rdsr(output logic [7:0] s);
    cs_lo(); send(8'h05); xbyte(8'h00, s, -1); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo(); send(8'h01); send(v); cs_hi();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a);
    cs_lo(); send(op); send(a[15:8]); send(a[7:0]);
  endtask

  function automatic logic fenced(input int b, input int a);
    case (b)
      0: return 1'b0;
      1: return a >= (N * 3) / 4;
      2: return a >= N / 2;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    logic [7:0] s, r;
    wt(5); rst_n = 1'b1; wt(5);

    chk("R11 oe low when deselected", {7'b0, miso_oe}, 8'h00);
    rdsr(s); chk("R1 status after reset", s, 8'h00);
    cs_lo(); wt(4); chk("R11 oe high when selected", {7'b0, miso_oe}, 8'h01); cs_hi();

    wren(); rdsr(s); chk("R1 WEL armed by 06h", s, 8'h02);

    hdr(8'h02, 16'h0000);
    for (int i = 0; i < N + 2; i++) begin
      logic [7:0] v;
      v = 8'((i * 7 + 3) & 255);
      send(v);
      exp_m[i % N] = v;
    end
    cs_hi();
    rdsr(s); chk("R7 WEL cleared after write frame", s, 8'h00);

    hdr(8'h03, 16'h0000);
    for (int i = 0; i < N + 2; i++) begin
      xbyte(8'((i * 29) ^ 8'h5A), r, -1);
      chk("R4 R5 sequential read with wrap", r, exp_m[i % N]);
    end
    cs_hi();

    hdr(8'h02, 16'h0010); send(~exp_m[16]); cs_hi();
    hdr(8'h03, 16'h0010); xbyte(8'hFF, r, -1); cs_hi();
    chk("R2 write without WEL ignored", r, exp_m[16]);

    wren(); hdr(8'h02, 16'hE321); send(8'h5A); cs_hi(); exp_m[8'h21] = 8'h5A;
    hdr(8'h03, 16'h1C21); xbyte(8'h00, r, -1); cs_hi();
    chk("R3 upper address bits ignored", r, 8'h5A);

    wren(); hdr(8'h02, 16'h0030);
    for (int i = 0; i < 5; i++) begin
      mosi = ~exp_m[48][7-i]; wt(HP); sck = 1'b1; wt(HP); sck = 1'b0;
    end
    cs_hi();
    hdr(8'h03, 16'h0030); xbyte(8'h00, r, -1); cs_hi();
    chk("R6 partial byte discarded", r, exp_m[48]);
    rdsr(s); chk("R7 WEL cleared after cut write", s, 8'h00);

    wrprot_n = 1'b0;
    for (int b = 0; b < 4; b++) begin
      wren(); wrsr(8'(b << 2));
      rdsr(s); chk("R8 status writable with PE=0, pin ignored", s, 8'(b << 2));
      for (int k = 0; k < 3; k++) begin
        int a0;
        a0 = (k == 0) ? N/2 - 1 : (k == 1) ? (N*3)/4 - 1 : N - 1;
        wren(); hdr(8'h02, 16'(a0));
        for (int j = 0; j < 2; j++) begin
          int a;
          logic [7:0] v;
          a = (a0 + j) % N;
          v = 8'(a ^ (b * 8'h35) ^ 8'hC3);
          send(v);
          if (!fenced(b, a)) exp_m[a] = v;
        end
        cs_hi();
        hdr(8'h03, 16'(a0));
        for (int j = 0; j < 2; j++) begin
          xbyte(8'h00, r, -1);
          chk("R9 fence decode", r, exp_m[(a0 + j) % N]);
        end
        cs_hi();
      end
    end

    wren(); wrsr(8'h80); rdsr(s); chk("R8 PE set", s, 8'h80);
    wren(); wrsr(8'h8C); rdsr(s); chk("R8 status locked by PE and pin low", s, 8'h80);
    wrprot_n = 1'b1;
    wrsr(8'h0C); rdsr(s); chk("R8 status locked without WEL", s, 8'h80);
    wren(); wrsr(8'h00); rdsr(s); chk("R8 status writable with pin high", s, 8'h00);

    wren();
    cs_lo(); send(8'hAB); send(8'h02); send(8'h00); send(8'h40); send(~exp_m[64]); cs_hi();
    rdsr(s); chk("R11 unknown command keeps WEL", s, 8'h02);
    hdr(8'h03, 16'h0040); xbyte(8'h00, r, -1); cs_hi();
    chk("R11 unknown command writes nothing", r, exp_m[64]);

    cs_lo(); send(8'h02); xbyte(8'h00, r, 3); send(8'h50);
    xbyte(8'h3C, r, 4); send(8'hC3); cs_hi();
    exp_m[80] = 8'h3C; exp_m[81] = 8'hC3;
    hdr(8'h03, 16'h0050); xbyte(8'h00, r, 2);
    chk("R10 read across pause", r, 8'h3C);
    xbyte(8'h00, r, -1); chk("R10 byte after pause", r, 8'hC3);
    cs_hi();

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R0 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule